// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Sub-Controller

This block gathers 32 interrupt requests from slow peripherals and turns them into three group summary lines plus one encoded vector for an upstream interrupt aggregator. Most sources are level-sensitive and show up in the status view exactly as they are driven. Three sources (bits 16, 22 and 28) are edge-sensitive: a rising edge sets a sticky latch that software removes by writing the status register with that bit at 0.

Software sees two 32-bit registers through a simple register port: the status view (latched edge bits merged with live level bits) and the enable mask. A request counts as pending only when its status bit and its mask bit are both 1. The sources are split into three fixed groups: bits 0 to 7, bits 8 to 15 and bits 16 to 31. Each group drives one summary line. The vector output gives the lowest pending source index plus 33, so the aggregator can use it directly as a global interrupt number. All outputs are plain control pins. No stream handshake applies.

Top module: `perif_irq_group`

## Requirements
- R1: After reset, the mask register reads 0. With all inputs low, the status view reads 0, all group lines are low and `vec_valid` is low.
- R2: For every bit other than 16, 22 and 28, the status view equals `irq_src` in the same cycle. Writes to the status register have no effect on those bits.
- R3: A rising edge on `irq_src` bit 16, 22 or 28, seen at a clock edge, sets that status bit from the next cycle onward. The bit stays set after the input falls.
- R4: A write with `reg_sel`=0 and a 0 in an edge bit position clears that edge bit at the next cycle. A 1 in that position leaves the bit unchanged.
- R5: If a rising edge on an edge bit arrives in the same cycle as a write that clears that bit, the bit is set after the clock.
- R6: A write with `reg_sel`=1 loads all 32 bits of the mask. Reading with `reg_sel`=1 returns the mask, and reading with `reg_sel`=0 returns the status view.
- R7: `grp_pend[0]` is the OR of status AND mask over bits 0 to 7. `grp_pend[1]` covers bits 8 to 15, and `grp_pend[2]` covers bits 16 to 31.
- R8: When any bit is both set in status and enabled in the mask, `vec_valid` is 1. `vec_num` then equals the lowest such bit index plus 33.
- R9: When no bit is both set and enabled, `vec_valid` is 0 and `vec_num` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Raw peripheral request lines |
| reg_sel | input | 1 | Register select: 0 = status, 1 = mask |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| grp_pend | output | 3 | Group summary lines (0: bits 0-7, 1: bits 8-15, 2: bits 16-31) |
| vec_valid | output | 1 | Some enabled source is pending |
| vec_num | output | 7 | Lowest pending enabled index plus 33, or 0 |

## Verification
The hardest situation to reach is a rising edge on an edge-sensitive source that lands in the very cycle of a status write clearing that same bit. Random stimulus seldom lines the two up. A directed step therefore raises bit 22 and writes a zero to it together, then checks that the latch survives. A second hard case is a level bit driven high while software writes status. The bench pairs status writes of all zeros with random level inputs so that any write leakage into level bits appears in the read-back.

// File: rtl/perif_irq_pkg.sv
package perif_irq_pkg;
  localparam int NSRC      = 32;
  localparam int NGRP      = 3;
  localparam int VEC_BASE  = 33;
  localparam logic [NSRC-1:0] EDGE_BITS = 32'h1041_0000;

  function automatic int grp_lo(input int g);
    case (g)
      0:       return 0;
      1:       return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int grp_hi(input int g);
    case (g)
      0:       return 7;
      1:       return 15;
      default: return NSRC - 1;
    endcase
  endfunction

  function automatic logic [NSRC-1:0] grp_bits(input int g);
    logic [NSRC-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++)
      if (i >= grp_lo(g) && i <= grp_hi(g)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int N = 32,
  parameter logic [N-1:0] EDGE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] clr,
  output logic [N-1:0] view
);
  logic [N-1:0] prev_q;
  logic [N-1:0] hold_q;
  logic [N-1:0] rise;

  assign rise = src & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      hold_q <= '0;
    end else begin
      prev_q <= src;
      // a new edge wins over a clear in the same cycle
      hold_q <= EDGE & (rise | (hold_q & ~clr));
    end
  end

  assign view = (hold_q & EDGE) | (src & ~EDGE);
endmodule

// File: rtl/irq_group_reduce.sv
module irq_group_reduce
  import perif_irq_pkg::*;
#(
  parameter int N = NSRC,
  parameter int G = NGRP
) (
  input  logic [N-1:0] pend,
  output logic [G-1:0] grp
);
  for (genvar g = 0; g < G; g++) begin : g_grp
    localparam logic [N-1:0] SEL = N'(grp_bits(g));
    assign grp[g] = |(pend & SEL);
  end
endmodule

// File: rtl/irq_prio_vec.sv
module irq_prio_vec #(
  parameter int N    = 32,
  parameter int BASE = 33,
  parameter int VW   = $clog2(N + BASE)
) (
  input  logic [N-1:0]  pend,
  output logic          valid,
  output logic [VW-1:0] num
);
  localparam int IW = $clog2(N);
  logic [IW-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend[i]) idx = IW'(i);
  end

  assign valid = |pend;
  assign num   = valid ? (VW'(idx) + VW'(BASE)) : '0;
endmodule

// File: rtl/perif_irq_group.sv
module perif_irq_group
  import perif_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] irq_src,
  input  logic        reg_sel,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [2:0]  grp_pend,
  output logic        vec_valid,
  output logic [6:0]  vec_num
);
  localparam int VW = $clog2(NSRC + VEC_BASE);

  logic [NSRC-1:0] stat_view;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] pend;

  assign clr_vec = (reg_we && !reg_sel) ? ~reg_wdata : '0;

  irq_edge_latch #(.N(NSRC), .EDGE(EDGE_BITS)) u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .src  (irq_src),
    .clr  (clr_vec),
    .view (stat_view)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                mask_q <= '0;
    else if (reg_we && reg_sel) mask_q <= reg_wdata;
  end

  assign pend      = stat_view & mask_q;
  assign reg_rdata = reg_sel ? mask_q : stat_view;

  irq_group_reduce #(.N(NSRC), .G(NGRP)) u_grp (
    .pend(pend),
    .grp (grp_pend)
  );

  irq_prio_vec #(.N(NSRC), .BASE(VEC_BASE), .VW(VW)) u_vec (
    .pend (pend),
    .valid(vec_valid),
    .num  (vec_num)
  );
endmodule

// File: rtl/perif_irq_group_chk.sv
module perif_irq_group_chk
  import perif_irq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] irq_src,
  input logic        reg_sel,
  input logic        reg_we,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic [2:0]  grp_pend,
  input logic        vec_valid,
  input logic [6:0]  vec_num,
  input logic [31:0] stat_view,
  input logic [31:0] mask_q
);
  logic [4:0]  low_idx;
  logic [31:0] below;
  assign low_idx = 5'(vec_num - 7'(VEC_BASE));
  assign below   = (32'd1 << low_idx) - 32'd1;

  for (genvar b = 0; b < NSRC; b++) begin : g_e
    if (EDGE_BITS[b]) begin : g_on
      assert_edge_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_src[b]) |=> stat_view[b]);
      assert_edge_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_src[b]) && reg_we && !reg_sel && !reg_wdata[b]) |=> stat_view[b]);
      assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_sel && !reg_wdata[b] && !irq_src[b]) |=> !stat_view[b]);
    end
  end

  assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> ((reg_rdata & ~EDGE_BITS) == (irq_src & ~EDGE_BITS)));

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel) |=> (mask_q == $past(reg_wdata)));

  assert_vec_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (stat_view[low_idx] && mask_q[low_idx] &&
                   ((stat_view & mask_q & below) == 32'd0)));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (vec_num == 7'd0 && grp_pend == 3'b000));

  assert_group_vs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_pend != 3'b000) == vec_valid);
endmodule

bind perif_irq_group perif_irq_group_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_src  (irq_src),
  .reg_sel  (reg_sel),
  .reg_we   (reg_we),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .grp_pend (grp_pend),
  .vec_valid(vec_valid),
  .vec_num  (vec_num),
  .stat_view(stat_view),
  .mask_q   (mask_q)
);

// File: tb/sim_perif_irq_group.sv
module sim_perif_irq_group;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EDGE_M = 32'h1041_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic        reg_sel = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  grp_pend;
  logic        vec_valid;
  logic [6:0]  vec_num;

  int applied = 0;
  int miscomp = 0;
  bit done = 1'b0;

  logic [31:0] m_edge = '0;
  logic [31:0] m_mask = '0;
  logic [31:0] m_prev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perif_irq_group u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_sel(reg_sel),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .grp_pend(grp_pend), .vec_valid(vec_valid), .vec_num(vec_num)
  );

  function automatic logic [31:0] f_status(input logic [31:0] e, input logic [31:0] s);
    return (e & EDGE_M) | (s & ~EDGE_M);
  endfunction

  function automatic logic [2:0] f_groups(input logic [31:0] p);
    return {|p[31:16], |p[15:8], |p[7:0]};
  endfunction

  function automatic logic [6:0] f_vec(input logic [31:0] p);
    for (int i = 0; i < 32; i++)
      if (p[i]) return 7'(i + 33);
    return 7'd0;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check just after, then advance the model
  task automatic step(input logic [31:0] s, input logic we, input logic sl,
                      input logic [31:0] wd, input string tag);
    logic [31:0] st, pd;
    @(negedge clk);
    irq_src = s; reg_we = we; reg_sel = sl; reg_wdata = wd;
    #1;
    st = f_status(m_edge, s);
    pd = st & m_mask;
    cmp(tag == "" ? (sl ? "R6" : "R2") : tag, "rdata", reg_rdata, sl ? m_mask : st);
    cmp(tag == "" ? "R7" : tag, "groups", 32'(grp_pend), 32'(f_groups(pd)));
    if (pd == 0) begin
      cmp(tag == "" ? "R9" : tag, "valid", 32'(vec_valid), 32'd0);
      cmp(tag == "" ? "R9" : tag, "vec", 32'(vec_num), 32'd0);
    end else begin
      cmp(tag == "" ? "R8" : tag, "valid", 32'(vec_valid), 32'd1);
      cmp(tag == "" ? "R8" : tag, "vec", 32'(vec_num), 32'(f_vec(pd)));
    end
    m_edge = EDGE_M & ((s & ~m_prev) | (m_edge & ~((we && !sl) ? ~wd : 32'd0)));
    if (we && sl) m_mask = wd;
    m_prev = s;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscomp++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] s, wd, lvl, edg;
    logic we, sl;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of status, mask, groups, vector
    step(32'h0, 1'b0, 1'b0, 32'h0, "R1");
    step(32'h0, 1'b0, 1'b1, 32'h0, "R1");
    // R6: enable everything
    step(32'h0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R6");
    // R3: edge on bit 16 is captured and held after the input falls
    step(32'h0001_0000, 1'b0, 1'b0, 32'h0, "R3");
    step(32'h0, 1'b0, 1'b0, 32'h0, "R3");
    step(32'h0, 1'b0, 1'b0, 32'h0, "R3");
    // R2: level bit 3 follows input and ignores a zero write; R8 vector 36
    step(32'h0000_0008, 1'b1, 1'b0, 32'h0000_0000, "R2");
    step(32'h0000_0008, 1'b0, 1'b0, 32'h0, "R8");
    // R4: writing 1 keeps bit 16, writing 0 clears it
    step(32'h0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R4");
    step(32'h0, 1'b1, 1'b0, 32'hFFFE_FFFF, "R4");
    step(32'h0, 1'b0, 1'b0, 32'h0, "R4");
    // R5: edge on bit 22 together with a clearing write
    step(32'h0040_0000, 1'b1, 1'b0, 32'h0000_0000, "R5");
    step(32'h0040_0000, 1'b0, 1'b0, 32'h0, "R5");
    // R9: mask off with pending inputs
    step(32'h0000_0F00, 1'b1, 1'b1, 32'h0, "R9");
    step(32'h0000_0F00, 1'b0, 1'b0, 32'h0, "R9");
    // R7: only the misc group enabled
    step(32'h0000_0F00, 1'b1, 1'b1, 32'h0000_FF00, "R7");
    step(32'h8000_0F01, 1'b0, 1'b0, 32'h0, "R7");

    for (int n = 0; n < 4000; n++) begin
      lvl = $urandom() & $urandom() & ~EDGE_M;
      edg = m_prev & EDGE_M;
      if ($urandom_range(0, 3) == 0) edg = edg ^ (EDGE_M & $urandom());
      s  = lvl | edg;
      we = ($urandom_range(0, 3) == 0);
      sl = $urandom_range(0, 1) == 1;
      wd = ($urandom_range(0, 1) == 1) ? $urandom() : ~(32'd1 << (16 + 6 * $urandom_range(0, 2)));
      step(s, we, sl, wd, "");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule